// File: doc/BRIEF.md
# Closed-Form Double-Error Locator Solver

This block takes the four syndromes of a received word of a binary double-error-correcting BCH code of length 15 and returns the two non-constant coefficients of the error locator polynomial Lambda(x) = A2·x^2 + A1·x + 1. It does not iterate. Both coefficients follow from one solution of the Peterson equations, in closed form, over GF(2^4). The block also reports how many errors the word holds (none, one or two). It raises a separate flag when the syndromes cannot belong to a correctable word.

A syndrome unit upstream drives `syn_valid` for one cycle with S1..S4 on the data inputs. Exactly two cycles later `loc_valid` pulses with the result. A root search downstream uses A1 and A2. Inputs may arrive on every cycle, and each one yields its own result two cycles on. Between results the outputs keep their last values.

Top module: `peterson_t2_locator`

## Requirements
- R1: Each cycle with `syn_valid` high produces a one-cycle `loc_valid` pulse exactly two clock cycles later. `loc_valid` is never high otherwise, and back-to-back inputs give back-to-back results.
- R2: While `rst_n` is low, `loc_valid`, `loc_a1`, `loc_a2`, `err_count` and `uncorrectable` are all zero.
- R3: When all four syndromes are zero, the result has `err_count` = 0, A1 = A2 = 0 and `uncorrectable` = 0.
- R4: For any result with `err_count` of 1 or 2, `loc_a1` equals the S1 of that input.
- R5: When S1 is nonzero and S3 equals S1^3, the result has `err_count` = 1, A2 = 0 and `uncorrectable` = 0.
- R6: When S1 is nonzero and S3 differs from S1^3, the result has `err_count` = 2 and A2 = (S3 + S1^3)·S1^-1. Arithmetic is over GF(2^4) reduced by x^4+x+1, with bit i of a 4-bit value holding the coefficient of x^i.
- R7: When S1 is zero and S3 is nonzero, `uncorrectable` = 1 and A1 = A2 = 0 with `err_count` = 0.
- R8: When S2 differs from S1^2, or S4 differs from S2^2, the word is reported as in R7 (`uncorrectable` = 1, A1 = A2 = 0, `err_count` = 0), whatever S1 and S3 are.
- R9: In cycles without `loc_valid`, `loc_a1`, `loc_a2`, `err_count` and `uncorrectable` hold the values of the most recent result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| syn_valid | input | 1 | Syndromes on the inputs are valid this cycle |
| syn1 | input | 4 | Syndrome S1 |
| syn2 | input | 4 | Syndrome S2 |
| syn3 | input | 4 | Syndrome S3 |
| syn4 | input | 4 | Syndrome S4 |
| loc_valid | output | 1 | Result strobe, two cycles after `syn_valid` |
| loc_a1 | output | 4 | Locator coefficient A1 |
| loc_a2 | output | 4 | Locator coefficient A2 |
| err_count | output | 2 | Number of errors: 0, 1 or 2 |
| uncorrectable | output | 1 | Syndromes are inconsistent or beyond two errors |

## Verification
The bench builds the block with its default field: 4-bit elements with the reduction polynomial x^4+x+1. With that field every pair of S1 and S3 fits in 256 inputs. All of them are streamed back to back with matching even syndromes, so the zero, single, double and uncorrectable classes are covered in full. A further sweep over every S1 corrupts S2 and then S4, and gaps between strobes expose the latency and the holding of results. The bench forms its expected values from log and antilog tables, which is a different route from the shift-and-reduce arithmetic in the design.

// File: rtl/gf16_peterson_pkg.sv
package gf16_peterson_pkg;

  localparam int GF_W = 4;
  localparam logic [GF_W:0] GF_POLY = 5'b10011;
  localparam int CNT_W = 2;

  typedef logic [GF_W-1:0] gf_t;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_ONE  = 2'd1,
    CLS_TWO  = 2'd2,
    CLS_FAIL = 2'd3
  } loc_class_e;

  // multiply by x, then reduce
  function automatic gf_t gf_xtime(input gf_t a);
    logic [GF_W:0] t;
    t = {a, 1'b0};
    if (t[GF_W]) t = t ^ GF_POLY;
    return t[GF_W-1:0];
  endfunction

  // shift-and-add product, most significant bit of b first
  function automatic gf_t gf_mul(input gf_t a, input gf_t b);
    gf_t acc;
    acc = '0;
    for (int i = GF_W - 1; i >= 0; i--) begin
      acc = gf_xtime(acc);
      if (b[i]) acc = acc ^ a;
    end
    return acc;
  endfunction

  function automatic gf_t gf_sq(input gf_t a);
    return gf_mul(a, a);
  endfunction

  function automatic gf_t gf_cube(input gf_t a);
    return gf_mul(gf_sq(a), a);
  endfunction

  // a^(2^W-2) as the product of a^(2^i), i = 1..W-1; zero maps to zero
  function automatic gf_t gf_inv(input gf_t a);
    gf_t r;
    gf_t p;
    r = gf_t'(1);
    p = a;
    for (int i = 1; i < GF_W; i++) begin
      p = gf_sq(p);
      r = gf_mul(r, p);
    end
    return (a == '0) ? '0 : r;
  endfunction

endpackage

// File: rtl/peterson_front.sv
module peterson_front
  import gf16_peterson_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  gf_t  s1,
  input  gf_t  s2,
  input  gf_t  s3,
  input  gf_t  s4,
  output logic mid_valid,
  output gf_t  mid_s1,
  output gf_t  mid_s3,
  output gf_t  mid_cube,
  output gf_t  mid_inv,
  output logic mid_bad
);

  // even syndromes of a binary code must be squares of lower ones
  logic even_mismatch;
  gf_t  s1_cube;
  gf_t  s1_inv;

  assign even_mismatch = (s2 != gf_sq(s1)) || (s4 != gf_sq(s2));
  assign s1_cube       = gf_cube(s1);
  assign s1_inv        = gf_inv(s1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_valid <= 1'b0;
      mid_s1    <= '0;
      mid_s3    <= '0;
      mid_cube  <= '0;
      mid_inv   <= '0;
      mid_bad   <= 1'b0;
    end else begin
      mid_valid <= in_valid;
      if (in_valid) begin
        mid_s1   <= s1;
        mid_s3   <= s3;
        mid_cube <= s1_cube;
        mid_inv  <= s1_inv;
        mid_bad  <= even_mismatch;
      end
    end
  end

  AST_INV_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_valid && mid_s1 != '0) |-> (gf_mul(mid_s1, mid_inv) == gf_t'(1))); // R6

endmodule

// File: rtl/peterson_solve.sv
module peterson_solve
  import gf16_peterson_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mid_valid,
  input  gf_t              mid_s1,
  input  gf_t              mid_s3,
  input  gf_t              mid_cube,
  input  gf_t              mid_inv,
  input  logic             mid_bad,
  output logic             res_valid,
  output gf_t              res_a1,
  output gf_t              res_a2,
  output logic [CNT_W-1:0] res_count,
  output logic             res_fail
);

  loc_class_e       cls;
  gf_t              a1_next;
  gf_t              a2_next;
  logic [CNT_W-1:0] count_next;

  always_comb begin
    if (mid_bad)                  cls = CLS_FAIL;
    else if (mid_s1 == '0)        cls = (mid_s3 == '0) ? CLS_NONE : CLS_FAIL;
    else if (mid_s3 == mid_cube)  cls = CLS_ONE;
    else                          cls = CLS_TWO;
  end

  always_comb begin
    a1_next    = '0;
    a2_next    = '0;
    count_next = '0;
    case (cls)
      CLS_ONE: begin
        a1_next    = mid_s1;
        count_next = CNT_W'(1);
      end
      CLS_TWO: begin
        a1_next    = mid_s1;
        a2_next    = gf_mul(mid_s3 ^ mid_cube, mid_inv);
        count_next = CNT_W'(2);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_a1    <= '0;
      res_a2    <= '0;
      res_count <= '0;
      res_fail  <= 1'b0;
    end else begin
      res_valid <= mid_valid;
      if (mid_valid) begin
        res_a1    <= a1_next;
        res_a2    <= a2_next;
        res_count <= count_next;
        res_fail  <= (cls == CLS_FAIL);
      end
    end
  end

  AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fail) |-> (res_a1 == '0 && res_a2 == '0 && res_count == '0)); // R7
  AST_SINGLE_A2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_count == CNT_W'(1)) |-> (res_a2 == '0 && res_a1 != '0)); // R5
  AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_fail && res_count == '0) |-> (res_a1 == '0 && res_a2 == '0)); // R3
  AST_TWO_A2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_count == CNT_W'(2)) |-> (res_a2 != '0 && !res_fail)); // R6

endmodule

// File: rtl/peterson_t2_locator.sv
module peterson_t2_locator
  import gf16_peterson_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             syn_valid,
  input  logic [GF_W-1:0]  syn1,
  input  logic [GF_W-1:0]  syn2,
  input  logic [GF_W-1:0]  syn3,
  input  logic [GF_W-1:0]  syn4,
  output logic             loc_valid,
  output logic [GF_W-1:0]  loc_a1,
  output logic [GF_W-1:0]  loc_a2,
  output logic [CNT_W-1:0] err_count,
  output logic             uncorrectable
);

  logic mid_valid;
  gf_t  mid_s1;
  gf_t  mid_s3;
  gf_t  mid_cube;
  gf_t  mid_inv;
  logic mid_bad;

  peterson_front u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (syn_valid),
    .s1        (syn1),
    .s2        (syn2),
    .s3        (syn3),
    .s4        (syn4),
    .mid_valid (mid_valid),
    .mid_s1    (mid_s1),
    .mid_s3    (mid_s3),
    .mid_cube  (mid_cube),
    .mid_inv   (mid_inv),
    .mid_bad   (mid_bad)
  );

  peterson_solve u_solve (
    .clk       (clk),
    .rst_n     (rst_n),
    .mid_valid (mid_valid),
    .mid_s1    (mid_s1),
    .mid_s3    (mid_s3),
    .mid_cube  (mid_cube),
    .mid_inv   (mid_inv),
    .mid_bad   (mid_bad),
    .res_valid (loc_valid),
    .res_a1    (loc_a1),
    .res_a2    (loc_a2),
    .res_count (err_count),
    .res_fail  (uncorrectable)
  );

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    syn_valid |-> ##2 loc_valid); // R1
  AST_NO_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
    loc_valid |-> $past(syn_valid, 2)); // R1
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !loc_valid |-> ($stable(loc_a1) && $stable(loc_a2) && $stable(err_count)
                    && $stable(uncorrectable))); // R9

endmodule

// File: tb/peterson_t2_locator_bench.sv
module peterson_t2_locator_bench;

  logic       clk;
  logic       rst_n;
  logic       syn_valid;
  logic [3:0] syn1, syn2, syn3, syn4;
  logic       loc_valid;
  logic [3:0] loc_a1, loc_a2;
  logic [1:0] err_count;
  logic       uncorrectable;

  int errors = 0;
  int checks = 0;

  int gexp [0:14];
  int glog [0:15];

  // two-deep expectation pipeline: {a1, a2, count, fail}
  logic       pv  [0:1];
  logic [3:0] pa1 [0:1];
  logic [3:0] pa2 [0:1];
  logic [1:0] pc  [0:1];
  logic       pf  [0:1];
  logic [3:0] last_a1, last_a2;
  logic [1:0] last_c;
  logic       last_f;

  peterson_t2_locator u_peterson_t2_locator (
    .clk(clk), .rst_n(rst_n), .syn_valid(syn_valid),
    .syn1(syn1), .syn2(syn2), .syn3(syn3), .syn4(syn4),
    .loc_valid(loc_valid), .loc_a1(loc_a1), .loc_a2(loc_a2),
    .err_count(err_count), .uncorrectable(uncorrectable)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int fmul(input int a, input int b);
    if (a == 0 || b == 0) return 0;
    return gexp[(glog[a] + glog[b]) % 15];
  endfunction

  function automatic int finv(input int a);
    return gexp[(15 - glog[a]) % 15];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle: check the result of the input two steps back, then drive
  task automatic step(input bit v, input int s1, input int s2, input int s3, input int s4);
    int e1, e2, ec;
    bit ef;
    string tag;
    @(negedge clk);
    if (pv[1]) begin
      check(loc_valid == 1'b1, "R1", "loc_valid", loc_valid, 1);
      if (pf[1]) tag = "R7/R8";
      else if (pc[1] == 0) tag = "R3";
      else if (pc[1] == 1) tag = "R5";
      else tag = "R6";
      check(loc_a2 == pa2[1] && err_count == pc[1] && uncorrectable == pf[1], tag,
            "a2/count/fail", {loc_a2, 2'b0, err_count, 3'b0, uncorrectable},
            {pa2[1], 2'b0, pc[1], 3'b0, pf[1]});
      check(loc_a1 == pa1[1], (pc[1] != 0) ? "R4" : tag, "a1", loc_a1, pa1[1]);
      last_a1 = pa1[1]; last_a2 = pa2[1]; last_c = pc[1]; last_f = pf[1];
    end else begin
      check(loc_valid == 1'b0, "R1", "loc_valid idle", loc_valid, 0);
      check(loc_a1 == last_a1 && loc_a2 == last_a2 && err_count == last_c
            && uncorrectable == last_f, "R9", "held outputs",
            {loc_a1, loc_a2}, {last_a1, last_a2});
    end
    syn_valid = v;
    syn1 = 4'(s1); syn2 = 4'(s2); syn3 = 4'(s3); syn4 = 4'(s4);
    // expected result from the requirements
    e1 = 0; e2 = 0; ec = 0; ef = 1'b0;
    if (s2 != fmul(s1, s1) || s4 != fmul(s2, s2)) ef = 1'b1;
    else if (s1 == 0) ef = (s3 != 0);
    else begin
      int cube;
      cube = fmul(s1, fmul(s1, s1));
      e1 = s1;
      if (s3 == cube) ec = 1;
      else begin
        ec = 2;
        e2 = fmul(s3 ^ cube, finv(s1));
      end
    end
    pv[1] = pv[0]; pa1[1] = pa1[0]; pa2[1] = pa2[0]; pc[1] = pc[0]; pf[1] = pf[0];
    pv[0] = v; pa1[0] = 4'(e1); pa2[0] = 4'(e2); pc[0] = 2'(ec); pf[0] = ef;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int x;
    x = 1;
    glog[0] = 0;
    for (int i = 0; i < 15; i++) begin
      gexp[i] = x;
      glog[x] = i;
      x = x << 1;
      if ((x & 16) != 0) x = x ^ 19;
    end
    for (int i = 0; i < 2; i++) begin
      pv[i] = 0; pa1[i] = 0; pa2[i] = 0; pc[i] = 0; pf[i] = 0;
    end
    last_a1 = 0; last_a2 = 0; last_c = 0; last_f = 0;
    rst_n = 1'b0;
    syn_valid = 1'b0;
    syn1 = 0; syn2 = 0; syn3 = 0; syn4 = 0;
    repeat (3) @(negedge clk);
    check(loc_valid == 0 && loc_a1 == 0 && loc_a2 == 0 && err_count == 0
          && uncorrectable == 0, "R2", "reset state",
          {loc_valid, loc_a1, loc_a2, err_count, uncorrectable}, 0);
    rst_n = 1'b1;

    // isolated strobe: latency and idle behaviour (R1, R9)
    step(1, 3, fmul(3, 3), 9, fmul(fmul(3, 3), fmul(3, 3)));
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);

    // exhaustive S1 x S3 streamed back to back with consistent S2, S4
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        step(1, a, fmul(a, a), b, fmul(fmul(a, a), fmul(a, a)));
      end
    end
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);

    // inconsistent even syndromes (R8)
    for (int a = 0; a < 16; a++) begin
      step(1, a, fmul(a, a) ^ 1, fmul(a, fmul(a, a)), fmul(fmul(a, a) ^ 1, fmul(a, a) ^ 1));
      step(1, a, fmul(a, a), (a * 5) & 15, fmul(fmul(a, a), fmul(a, a)) ^ 8);
      step(0, 0, 0, 0, 0);
    end
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    finish_run();
  end

endmodule